// File: doc/BRIEF.md
# Chip Erase Retry Controller

This block is a host-side sequencer that erases an electrically erasable EPROM by retrying. One start pulse launches a run. Each attempt has four steps. The controller first asks for the high programming supply and for the high level on the erase-select address line, with chip enable active and all address lines at zero. It then drives the program strobe low for one long, chip-wide erase pulse, holds the same levels for a short hold window, and releases the high-voltage requests.

With the high-voltage requests released, the controller asks for the reduced verify supply and blank-checks the array. It reads every address in ascending order and compares each byte with all-ones. The first byte that is not all-ones ends the check for that attempt, and the next attempt starts. A run ends when every byte reads back as all-ones (pass) or when the attempt limit is used up (fail).

All durations are counted in clock cycles and set by parameters: setup, pulse, hold and read access. At 50 MHz the defaults give 2 µs setup, 100 ms pulse, 2 µs hold and 80 ns access. Producing the actual voltages is left to external circuits that respond to the request outputs.

The state machine has six states:

- `ST_IDLE` moves to `ST_SETUP` when start is seen.
- `ST_SETUP` moves to `ST_PULSE` when its timer expires.
- `ST_PULSE` moves to `ST_HOLD` when its timer expires.
- `ST_HOLD` moves to `ST_READ` when its timer expires.
- `ST_READ` has four exits:
  - it stays in `ST_READ` and steps to the next address when a byte is blank and it is not the last one;
  - it moves to `ST_END` with pass when the last byte is blank;
  - it moves to `ST_SETUP` on a mismatch while attempts remain;
  - it moves to `ST_END` with fail on a mismatch in the final attempt.
- `ST_END` always moves to `ST_IDLE`.

Top module: `erase_retry_ctrl`

## Requirements
- R1: After reset and while idle, `chip_en_n`, `out_en_n` and `prog_n` are 1; `hv_req`, `erase_sel_hv_req`, `verify_lo_req`, `busy` and `done` are 0; `addr` is 0.
- R2: A start pulse seen while idle leads, on the next clock, to `SETUP_CYC` cycles with `chip_en_n`=0, `out_en_n`=1, `prog_n`=1, `addr`=0, `hv_req`=1 and `erase_sel_hv_req`=1, and with `busy`=1.
- R3: The erase pulse follows the setup window. It holds `prog_n`=0 for exactly `PULSE_CYC` cycles, with the setup levels of the other outputs unchanged.
- R4: After `prog_n` returns to 1, `addr`=0, chip enable and both high-voltage requests stay as they were for `HOLD_CYC` cycles.
- R5: During the blank check, `hv_req` and `erase_sel_hv_req` are 0, and `verify_lo_req`, `chip_en_n`=0 and `out_en_n`=0 are asserted. Addresses go from 0 upward, each held for `ACCESS_CYC` cycles, and `rd_data` is compared with all-ones in the last cycle of each address.
- R6: A byte other than all-ones ends the check at that address. If attempts remain, the next cycle begins a new setup window.
- R7: At most `MAX_TRIES` erase pulses are issued per run. A check that passes on attempt `MAX_TRIES` gives pass=1. A mismatch on attempt `MAX_TRIES` ends the run with pass=0.
- R8: A run ends with `done`=1 for exactly one cycle, with `busy`=0 and all drive outputs at their idle levels. `pass` carries the result from that cycle until the next accepted start, which clears it.
- R9: Start pulses while `busy`=1 have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run (taken only when idle) |
| rd_data | input | 8 | Byte read from the device |
| chip_en_n | output | 1 | Device chip enable, active low |
| out_en_n | output | 1 | Device output enable, active low |
| prog_n | output | 1 | Program/erase strobe, active low |
| addr | output | ADDR_W | Device address |
| hv_req | output | 1 | Request for high programming supply |
| erase_sel_hv_req | output | 1 | Request for high level on the erase-select address line |
| verify_lo_req | output | 1 | Request for reduced verify supply |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run flag |
| pass | output | 1 | Result of the last run |

## Verification
The device model is a 16-byte array. Each byte has its own count of erase pulses needed before it reads all-ones. A run where every byte is blank after one pulse shows the bare single-attempt sequence. A run with late bytes at the middle and final addresses shows that the sweep reaches the last address and restarts the setup step on a mismatch; a start pulse injected mid-run must leave that trace unchanged. A byte at address 0 that needs exactly the limit tells early abort apart from a full sweep and checks that the last allowed attempt can still pass. A byte that never erases checks that the run fails after the limit, and a clean run afterwards shows the result flag cleared and set again.

// File: rtl/erc_pkg.sv
package erc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_READ,
        ST_END
    } erc_state_t;

    function automatic int unsigned erc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/erc_timer.sv
module erc_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/erc_scan.sv
module erc_scan #(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] cur,
    output logic              at_last
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cur <= '0;
        else if (step)     cur <= cur + 1'b1;
    end

    assign at_last = &cur;
endmodule

// File: rtl/erc_tries.sv
module erc_tries #(
    parameter int unsigned MAX_TRIES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic final_try
);
    localparam int unsigned CW = $clog2(MAX_TRIES + 1);

    logic [CW-1:0] used;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) used <= '0;
        else if (bump)     used <= used + 1'b1;
    end

    assign final_try = (used == CW'(MAX_TRIES - 1));
endmodule

// File: rtl/erase_retry_ctrl.sv
module erase_retry_ctrl
    import erc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 17,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned MAX_TRIES  = 20,
    parameter int unsigned SETUP_CYC  = 100,
    parameter int unsigned PULSE_CYC  = 5000000,
    parameter int unsigned HOLD_CYC   = 100,
    parameter int unsigned ACCESS_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] rd_data,
    output logic              chip_en_n,
    output logic              out_en_n,
    output logic              prog_n,
    output logic [ADDR_W-1:0] addr,
    output logic              hv_req,
    output logic              erase_sel_hv_req,
    output logic              verify_lo_req,
    output logic              busy,
    output logic              done,
    output logic              pass
);
    localparam int unsigned TMR_MAX =
        erc_max(erc_max(SETUP_CYC, PULSE_CYC), erc_max(HOLD_CYC, ACCESS_CYC));
    localparam int unsigned TMR_W = $clog2(TMR_MAX + 1);

    erc_state_t        state, state_nxt;
    logic              tmr_load, tmr_expired;
    logic [TMR_W-1:0]  tmr_val;
    logic              scan_clr, scan_step, scan_last;
    logic [ADDR_W-1:0] scan_addr;
    logic              tries_clr, tries_bump, tries_final;
    logic              pass_set, pass_q;
    logic              blank;

    assign blank = (rd_data == {DATA_W{1'b1}});

    erc_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
    );

    erc_scan #(.ADDR_W(ADDR_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .clr(scan_clr), .step(scan_step),
        .cur(scan_addr), .at_last(scan_last)
    );

    erc_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk(clk), .rst_n(rst_n), .clr(tries_clr), .bump(tries_bump), .final_try(tries_final)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pass_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (tries_clr)     pass_q <= 1'b0;
            else if (pass_set) pass_q <= 1'b1;
        end
    end

    always_comb begin
        state_nxt  = state;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        scan_clr   = 1'b0;
        scan_step  = 1'b0;
        tries_clr  = 1'b0;
        tries_bump = 1'b0;
        pass_set   = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                state_nxt = ST_SETUP;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(SETUP_CYC - 1);
                tries_clr = 1'b1;
            end
            ST_SETUP: if (tmr_expired) begin
                state_nxt = ST_PULSE;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(PULSE_CYC - 1);
            end
            ST_PULSE: if (tmr_expired) begin
                state_nxt = ST_HOLD;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(HOLD_CYC - 1);
            end
            ST_HOLD: if (tmr_expired) begin
                state_nxt = ST_READ;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(ACCESS_CYC - 1);
                scan_clr  = 1'b1;
            end
            ST_READ: if (tmr_expired) begin
                if (!blank) begin
                    if (tries_final) begin
                        state_nxt = ST_END;
                    end else begin
                        state_nxt  = ST_SETUP;
                        tries_bump = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = TMR_W'(SETUP_CYC - 1);
                    end
                end else if (scan_last) begin
                    state_nxt = ST_END;
                    pass_set  = 1'b1;
                end else begin
                    scan_step = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(ACCESS_CYC - 1);
                end
            end
            ST_END: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        chip_en_n        = 1'b1;
        out_en_n         = 1'b1;
        prog_n           = 1'b1;
        addr             = '0;
        hv_req           = 1'b0;
        erase_sel_hv_req = 1'b0;
        verify_lo_req    = 1'b0;
        busy             = 1'b1;
        done             = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_SETUP, ST_HOLD: begin
                chip_en_n        = 1'b0;
                hv_req           = 1'b1;
                erase_sel_hv_req = 1'b1;
            end
            ST_PULSE: begin
                chip_en_n        = 1'b0;
                prog_n           = 1'b0;
                hv_req           = 1'b1;
                erase_sel_hv_req = 1'b1;
            end
            ST_READ: begin
                chip_en_n     = 1'b0;
                out_en_n      = 1'b0;
                verify_lo_req = 1'b1;
                addr          = scan_addr;
            end
            ST_END: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign pass = pass_q;
endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned MAX_TRIES = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              chip_en_n,
    input logic              out_en_n,
    input logic              prog_n,
    input logic [ADDR_W-1:0] addr,
    input logic              hv_req,
    input logic              erase_sel_hv_req,
    input logic              verify_lo_req,
    input logic              busy,
    input logic              done
);
    localparam int unsigned CW = $clog2(MAX_TRIES + 2);

    logic          prog_q;
    logic [CW-1:0] pulses_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q      <= 1'b1;
            pulses_seen <= '0;
        end else begin
            prog_q <= prog_n;
            if (start && !busy)      pulses_seen <= '0;
            else if (prog_q && !prog_n) pulses_seen <= pulses_seen + 1'b1;
        end
    end

    AST_PULSE_HV_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (hv_req && erase_sel_hv_req && !chip_en_n && out_en_n)); // R3
    AST_PULSE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (addr == '0)); // R2
    AST_PULSE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n) |-> ($past(hv_req) && !$past(chip_en_n))); // R2
    AST_VERIFY_NO_HV: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_n |-> (verify_lo_req && !hv_req && !erase_sel_hv_req && prog_n)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && chip_en_n && !hv_req)); // R8
    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_seen <= CW'(MAX_TRIES)); // R7
endmodule

bind erase_retry_ctrl erc_checker #(.ADDR_W(ADDR_W), .MAX_TRIES(MAX_TRIES)) u_erc_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .prog_n(prog_n), .addr(addr), .hv_req(hv_req), .erase_sel_hv_req(erase_sel_hv_req),
    .verify_lo_req(verify_lo_req), .busy(busy), .done(done)
);

// File: tb/test_erase_retry_ctrl.sv
module test_erase_retry_ctrl;
    localparam int AW = 4;
    localparam int NB = 1 << AW;
    localparam int TRIES = 20;
    localparam int S = 3, P = 5, H = 2, A = 2;

    typedef struct {
        logic ce, oe, pg, hv, es, lo, bz, dn, ps;
        int   ad;
        string req;
    } vec_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] rd_data;
    logic chip_en_n, out_en_n, prog_n, hv_req, erase_sel_hv_req, verify_lo_req, busy, done, pass;
    logic [AW-1:0] addr;

    int vectors = 0, miscompares = 0;
    int need [NB];
    int pulses = 0;
    vec_t q[$];

    always #10 clk = ~clk;

    erase_retry_ctrl #(.ADDR_W(AW), .DATA_W(8), .MAX_TRIES(TRIES), .SETUP_CYC(S),
                       .PULSE_CYC(P), .HOLD_CYC(H), .ACCESS_CYC(A)) i_erase_retry_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_data(rd_data),
        .chip_en_n(chip_en_n), .out_en_n(out_en_n), .prog_n(prog_n), .addr(addr),
        .hv_req(hv_req), .erase_sel_hv_req(erase_sel_hv_req), .verify_lo_req(verify_lo_req),
        .busy(busy), .done(done), .pass(pass)
    );

    // device model: a byte reads all-ones once it has seen enough erase pulses
    always @(posedge prog_n) if (rst_n) pulses <= pulses + 1;
    always_comb begin
        if (!chip_en_n && !out_en_n)
            rd_data = (pulses >= need[addr]) ? 8'hFF : {addr, 4'hE};
        else
            rd_data = 8'h00;
    end

    function automatic vec_t mk(logic ce, logic oe, logic pg, logic hv, logic es, logic lo,
                                logic bz, logic dn, int ad, logic ps, string req);
        vec_t v;
        v.ce = ce; v.oe = oe; v.pg = pg; v.hv = hv; v.es = es; v.lo = lo;
        v.bz = bz; v.dn = dn; v.ad = ad; v.ps = ps; v.req = req;
        return v;
    endfunction

    task automatic cmp(input vec_t e);
        vectors++;
        if (chip_en_n !== e.ce || out_en_n !== e.oe || prog_n !== e.pg || hv_req !== e.hv ||
            erase_sel_hv_req !== e.es || verify_lo_req !== e.lo || busy !== e.bz ||
            done !== e.dn || pass !== e.ps || int'(addr) !== e.ad) begin
            miscompares++;
            $display("FAIL %s: got ce%b oe%b pg%b hv%b es%b lo%b bz%b dn%b ps%b a%0d exp ce%b oe%b pg%b hv%b es%b lo%b bz%b dn%b ps%b a%0d",
                     e.req, chip_en_n, out_en_n, prog_n, hv_req, erase_sel_hv_req, verify_lo_req,
                     busy, done, pass, addr, e.ce, e.oe, e.pg, e.hv, e.es, e.lo, e.bz, e.dn, e.ps, e.ad);
        end
    endtask

    // behavioural expectation of one run, cycle by cycle
    task automatic build(output logic result);
        result = 1'b0;
        for (int k = 1; k <= TRIES; k++) begin
            bit clean = 1'b1;
            for (int c = 0; c < S; c++) q.push_back(mk(0,1,1,1,1,0,1,0,0,0,"R2"));
            for (int c = 0; c < P; c++) q.push_back(mk(0,1,0,1,1,0,1,0,0,0,"R3"));
            for (int c = 0; c < H; c++) q.push_back(mk(0,1,1,1,1,0,1,0,0,0,"R4"));
            for (int a = 0; a < NB; a++) begin
                for (int c = 0; c < A; c++) q.push_back(mk(0,0,1,0,0,1,1,0,a,0,"R5"));
                if (need[a] > k) begin clean = 1'b0; break; end   // R6 abort
            end
            if (clean) begin result = 1'b1; break; end
        end
        q.push_back(mk(1,1,1,0,0,0,0,1,0,result,"R7"));
    endtask

    task automatic run(input int poke);
        logic res;
        int idx = 0;
        build(res);
        pulses = 0;
        @(negedge clk); start = 1'b1;
        while (q.size() > 0) begin
            @(negedge clk);
            start = (idx == poke);   // R9 start while busy
            cmp(q.pop_front());
            idx++;
        end
        @(negedge clk); start = 1'b0;
        cmp(mk(1,1,1,0,0,0,0,0,0,res,"R8"));
        @(negedge clk);
        cmp(mk(1,1,1,0,0,0,0,0,0,res,"R8"));
    endtask

    task automatic fill(input int v);
        for (int i = 0; i < NB; i++) need[i] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hung run, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        fill(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp(mk(1,1,1,0,0,0,0,0,0,0,"R1"));
        @(negedge clk);
        cmp(mk(1,1,1,0,0,0,0,0,0,0,"R1"));

        fill(1);                          // single attempt, full sweep
        run(-1);

        fill(1); need[7] = 2; need[15] = 3;   // late bytes mid and last, R9 poke
        run(4);

        fill(1); need[0] = TRIES;         // passes on the last allowed attempt, R7
        run(-1);

        fill(1); need[5] = TRIES + 1;     // never blank, R7 fail
        run(-1);

        fill(1);                          // pass cleared then set again, R8
        run(-1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule